// File: doc/BRIEF.md
# Command-Driven SPI Slave with Stall Timeout

This block is a slave on a four-wire serial bus that moves one word in each direction every time the master pulls slave-select low. A host loads a 16-bit data word, a timeout count and a command byte. The command byte's upper nibble holds the flags and must be one of four legal values. Its lower nibble gives the word length, from 1 to 16 bits. Flag bit 6 picks which clock level ends each bit.

When slave-select falls, the block checks the command. It moves the word's top bit to buffer bit 15, then walks through the bits. For each bit it waits for the drive level on the serial clock and puts buffer bit 15 on MISO. It then waits for the opposite level and captures MOSI into buffer bit 0. A watchdog, reloaded at every level wait, aborts a transfer whose clock stops.

When the transfer ends, the command register reads zero, which tells the host the block is ready. The status register tells the host whether anything went wrong.

Top module: `spiw_top`

## Requirements
- R1: A command is legal when bit 4 is 1 and bit 5 is 0, so the legal upper nibbles are 1, 5, 9 and D. Bit 7 (transmit) does not change the data movement: every legal command sends and receives at the same time.
- R2: On a slave-select fall with an illegal command, status bit 4 is set and the command register is cleared. No transfer happens: busy stays low and the buffer is unchanged.
- R3: The command's low nibble sets the word length. Values 1 to 15 give that many bits, and 0 gives 16 bits.
- R4: At the start, the buffer is shifted left by (16 minus length) places with zeros filled in. MISO therefore carries the low length bits of the loaded word, most significant bit first.
- R5: Each captured MOSI bit enters buffer bit 0 as the buffer shifts left. After a complete transfer, the buffer holds the received word right-aligned, with zeros above it.
- R6: With bit 6 clear, each bit waits for the serial clock to be high, then drives MISO. It then waits for the clock to be low and samples MOSI.
- R7: With bit 6 set, each bit waits for the serial clock to be low, then drives MISO. It then waits for the clock to be high and samples MOSI.
- R8: Every level wait reloads the watchdog from the timeout register. If the watchdog sees no awaited level for timeout × TICK_DIV system clocks, the transfer aborts: status bit 7 is set, the command register is cleared and busy drops.
- R9: A timeout value of 0 counts as 256.
- R10: A completed transfer clears the command register and drops busy. Both status error bits stay set until the host writes a new command, and that write clears them.
- R11: Busy is high for the whole transfer. Host writes to the buffer and command registers while busy have no effect.
- R12: A transfer starts only on a falling edge of the synchronised slave-select. Clock activity while slave-select is high starts nothing. After reset, command, status and buffer read zero and busy is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_wr | input | 1 | Write strobe for the command register |
| cmd_wdata | input | 8 | Command value to write |
| buf_wr | input | 1 | Write strobe for the data buffer |
| buf_wdata | input | 16 | Data word to write |
| tmo_wr | input | 1 | Write strobe for the timeout register |
| tmo_wdata | input | 8 | Timeout count, in ticks (0 means 256) |
| cmd_rd | output | 8 | Command register; zero when ready |
| buf_rd | output | 16 | Data buffer |
| status_rd | output | 8 | Status register: bit 4 illegal command, bit 7 aborted transfer |
| busy | output | 1 | High while a transfer runs |
| spi_sclk | input | 1 | Serial clock from the master (asynchronous) |
| spi_mosi | input | 1 | Serial data from the master (asynchronous) |
| spi_ss_n | input | 1 | Active-low slave-select (asynchronous) |
| spi_miso | output | 1 | Serial data to the master |

## Verification
The bench builds the block with TICK_DIV set to 4 instead of the default 32. A 10-count timeout then expires about 40 cycles after the last clock level change, and the 256-count case for a zero timeout expires after about 1024 cycles. Both aborts can be bracketed tightly in a short run. SYNC_STAGES stays at 2, so MISO settles a few cycles after each serial clock level change. The bench's half period of 12 cycles leaves room for that settling time.

// File: rtl/spiw_pkg.sv
package spiw_pkg;

    localparam int DATA_W = 16;
    localparam int CMD_W  = 8;
    localparam int LEN_W  = $clog2(DATA_W) + 1;

    // status flag positions
    localparam int ST_BADCMD = 4;
    localparam int ST_ABORT  = 7;

    // command flag positions
    localparam int CB_ONE    = 4;
    localparam int CB_MASTER = 5;
    localparam int CB_RISE   = 6;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_DRIVE  = 2'd1,
        PH_SAMPLE = 2'd2
    } phase_e;

    function automatic logic cmd_legal(input logic [CMD_W-1:0] c);
        return c[CB_ONE] && !c[CB_MASTER];
    endfunction

    function automatic logic [LEN_W-1:0] cmd_len(input logic [CMD_W-1:0] c);
        logic [LEN_W-1:0] l;
        l = LEN_W'(c[3:0]);
        if (l == '0) l = LEN_W'(DATA_W);
        return l;
    endfunction

endpackage

// File: rtl/spiw_sync.sv
module spiw_sync #(
    parameter int               WIDTH   = 1,
    parameter int               STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    logic [WIDTH-1:0] chain_q [STAGES];
    logic [WIDTH-1:0] chain_d [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                assign chain_d[s] = async_i;
            end else begin : g_rest
                assign chain_d[s] = chain_q[s-1];
            end
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q[s] <= RST_VAL;
                else        chain_q[s] <= chain_d[s];
            end
        end
    endgenerate

    assign sync_o = chain_q[STAGES-1];

endmodule

// File: rtl/spiw_tick.sv
module spiw_tick #(
    parameter int DIV = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic tick
);

    generate
        if (DIV <= 1) begin : g_pass
            logic unused_restart;
            assign unused_restart = restart;
            assign tick = 1'b1;
        end else begin : g_div
            localparam int CW = $clog2(DIV);
            localparam logic [CW-1:0] LAST = CW'(DIV - 1);
            logic [CW-1:0] cnt_d, cnt_q;

            always_comb begin
                cnt_d = cnt_q;
                if (restart)            cnt_d = '0;
                else if (cnt_q == LAST) cnt_d = '0;
                else                    cnt_d = cnt_q + 1'b1;
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) cnt_q <= '0;
                else        cnt_q <= cnt_d;
            end

            assign tick = !restart && (cnt_q == LAST);

            // R8: ticks are spaced, never two in a row
            AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
                tick |=> !tick); // R8
        end
    endgenerate

endmodule

// File: rtl/spiw_core.sv
module spiw_core
    import spiw_pkg::*;
#(
    parameter int TMO_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_wr,
    input  logic [CMD_W-1:0]  cmd_wdata,
    input  logic              buf_wr,
    input  logic [DATA_W-1:0] buf_wdata,
    input  logic              tmo_wr,
    input  logic [TMO_W-1:0]  tmo_wdata,
    input  logic              sclk_s,
    input  logic              mosi_s,
    input  logic              ss_fall,
    input  logic              tick,
    output logic              tick_restart,
    output logic [CMD_W-1:0]  cmd_o,
    output logic [DATA_W-1:0] buf_o,
    output logic [7:0]        status_o,
    output logic              busy_o,
    output logic              miso_o
);

    localparam int TMR_W = TMO_W + 1;
    localparam int SH_W  = LEN_W;

    typedef struct packed {
        phase_e              ph;
        logic [CMD_W-1:0]    cmd;
        logic [DATA_W-1:0]   data;
        logic [7:0]          status;
        logic [TMO_W-1:0]    tmo;
        logic [LEN_W-1:0]    left;
        logic [TMR_W-1:0]    tmr;
        logic                miso;
    } core_s;

    core_s st_d, st_q;

    logic [TMR_W-1:0] reload_val;
    logic             want_lvl;
    logic [LEN_W-1:0] len_w;
    logic [SH_W-1:0]  align_sh;
    logic             restart_d;

    assign reload_val = (st_q.tmo == '0) ? TMR_W'(1 << TMO_W) : TMR_W'(st_q.tmo);
    assign len_w      = cmd_len(st_q.cmd);
    assign align_sh   = SH_W'(DATA_W) - SH_W'(len_w);

    always_comb begin
        // level awaited in the current phase
        if (st_q.ph == PH_DRIVE) want_lvl = st_q.cmd[CB_RISE] ? 1'b0 : 1'b1;
        else                     want_lvl = st_q.cmd[CB_RISE] ? 1'b1 : 1'b0;
    end

    always_comb begin
        st_d      = st_q;
        restart_d = 1'b0;
        if (tmo_wr) st_d.tmo = tmo_wdata;

        unique case (st_q.ph)
            PH_IDLE: begin
                if (ss_fall) begin
                    if (cmd_legal(st_q.cmd)) begin
                        st_d.data = st_q.data << align_sh;
                        st_d.left = len_w;
                        st_d.tmr  = reload_val;
                        st_d.ph   = PH_DRIVE;
                        restart_d = 1'b1;
                    end else begin
                        st_d.status[ST_BADCMD] = 1'b1;
                        st_d.cmd               = '0;
                    end
                end else begin
                    if (cmd_wr) begin
                        st_d.cmd    = cmd_wdata;
                        st_d.status = '0;
                    end
                    if (buf_wr) st_d.data = buf_wdata;
                end
            end

            PH_DRIVE, PH_SAMPLE: begin
                if (sclk_s == want_lvl) begin
                    st_d.tmr  = reload_val;
                    restart_d = 1'b1;
                    if (st_q.ph == PH_DRIVE) begin
                        st_d.miso = st_q.data[DATA_W-1];
                        st_d.data = {st_q.data[DATA_W-2:0], 1'b0};
                        st_d.ph   = PH_SAMPLE;
                    end else begin
                        st_d.data[0] = mosi_s;
                        if (st_q.left == LEN_W'(1)) begin
                            st_d.ph   = PH_IDLE;
                            st_d.cmd  = '0;
                            st_d.left = '0;
                            restart_d = 1'b0;
                        end else begin
                            st_d.left = st_q.left - 1'b1;
                            st_d.ph   = PH_DRIVE;
                        end
                    end
                end else if (tick) begin
                    if (st_q.tmr == TMR_W'(1)) begin
                        st_d.ph               = PH_IDLE;
                        st_d.cmd              = '0;
                        st_d.left             = '0;
                        st_d.status[ST_ABORT] = 1'b1;
                    end else begin
                        st_d.tmr = st_q.tmr - 1'b1;
                    end
                end
            end

            default: st_d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.ph   <= PH_IDLE;
        end else begin
            st_q      <= st_d;
        end
    end

    assign tick_restart = restart_d;
    assign cmd_o        = st_q.cmd;
    assign buf_o        = st_q.data;
    assign status_o     = st_q.status;
    assign busy_o       = (st_q.ph != PH_IDLE);
    assign miso_o       = st_q.miso;

    AST_BUSY_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> cmd_legal(cmd_o)); // R1

    AST_LEFT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> (st_q.left != '0 && st_q.left <= LEN_W'(DATA_W))); // R3

    AST_END_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> (cmd_o == '0)); // R10

    AST_BUSY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && cmd_wr) |=> (cmd_o == $past(cmd_o) || cmd_o == '0)); // R11

    AST_BADCMD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status_o[ST_BADCMD]) |-> !busy_o); // R2

    AST_TMR_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> (st_q.tmr != '0)); // R8

endmodule

// File: rtl/spiw_top.sv
module spiw_top
    import spiw_pkg::*;
#(
    parameter int TICK_DIV    = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cmd_wr,
    input  logic [7:0]  cmd_wdata,
    input  logic        buf_wr,
    input  logic [15:0] buf_wdata,
    input  logic        tmo_wr,
    input  logic [7:0]  tmo_wdata,
    output logic [7:0]  cmd_rd,
    output logic [15:0] buf_rd,
    output logic [7:0]  status_rd,
    output logic        busy,
    input  logic        spi_sclk,
    input  logic        spi_mosi,
    input  logic        spi_ss_n,
    output logic        spi_miso
);

    logic [2:0] pins_s;
    logic       ss_prev_q, ss_prev_d;
    logic       ss_fall;
    logic       tick, tick_restart;

    spiw_sync #(
        .WIDTH   (3),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (3'b100)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({spi_ss_n, spi_mosi, spi_sclk}),
        .sync_o  (pins_s)
    );

    assign ss_prev_d = pins_s[2];
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ss_prev_q <= 1'b1;
        else        ss_prev_q <= ss_prev_d;
    end
    assign ss_fall = ss_prev_q && !pins_s[2];

    spiw_tick #(
        .DIV (TICK_DIV)
    ) u_tick (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (tick_restart),
        .tick    (tick)
    );

    spiw_core #(
        .TMO_W (8)
    ) u_core (
        .clk          (clk),
        .rst_n        (rst_n),
        .cmd_wr       (cmd_wr),
        .cmd_wdata    (cmd_wdata),
        .buf_wr       (buf_wr),
        .buf_wdata    (buf_wdata),
        .tmo_wr       (tmo_wr),
        .tmo_wdata    (tmo_wdata),
        .sclk_s       (pins_s[0]),
        .mosi_s       (pins_s[1]),
        .ss_fall      (ss_fall),
        .tick         (tick),
        .tick_restart (tick_restart),
        .cmd_o        (cmd_rd),
        .buf_o        (buf_rd),
        .status_o     (status_rd),
        .busy_o       (busy),
        .miso_o       (spi_miso)
    );

    AST_START_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(ss_fall)); // R12

endmodule

// File: tb/spiw_top_tb.sv
module spiw_top_tb;

    localparam int H = 12;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_wr = 1'b0, buf_wr = 1'b0, tmo_wr = 1'b0;
    logic [7:0]  cmd_wdata = '0, tmo_wdata = '0;
    logic [15:0] buf_wdata = '0;
    logic [7:0]  cmd_rd, status_rd;
    logic [15:0] buf_rd;
    logic        busy, spi_miso;
    logic        spi_sclk = 1'b0, spi_mosi = 1'b0, spi_ss_n = 1'b1;

    int checks = 0;
    int errors = 0;

    typedef struct {
        string       tag;
        logic [7:0]  cmd;
        logic [7:0]  status;
        logic [15:0] data;
        logic        chk_data;
    } exp_s;

    exp_s sb_q[$];

    always #2.5 clk = ~clk;

    spiw_top #(.TICK_DIV(4), .SYNC_STAGES(2)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .cmd_wr(cmd_wr), .cmd_wdata(cmd_wdata),
        .buf_wr(buf_wr), .buf_wdata(buf_wdata),
        .tmo_wr(tmo_wr), .tmo_wdata(tmo_wdata),
        .cmd_rd(cmd_rd), .buf_rd(buf_rd), .status_rd(status_rd), .busy(busy),
        .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_ss_n(spi_ss_n),
        .spi_miso(spi_miso)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic host_wr(input int which, input logic [15:0] v);
        @(negedge clk);
        case (which)
            0: begin cmd_wr = 1'b1; cmd_wdata = v[7:0]; end
            1: begin buf_wr = 1'b1; buf_wdata = v; end
            default: begin tmo_wr = 1'b1; tmo_wdata = v[7:0]; end
        endcase
        @(negedge clk);
        cmd_wr = 1'b0; buf_wr = 1'b0; tmo_wr = 1'b0;
    endtask

    // one bit as seen by the master; returns MISO seen before the sample edge
    task automatic bit_xfer(input logic rise, input logic mo, output logic mi);
        spi_mosi = mo;
        spi_sclk = rise ? 1'b0 : 1'b1;
        cyc(H - 1);
        mi = spi_miso;
        cyc(1);
        spi_sclk = rise ? 1'b1 : 1'b0;
        cyc(H);
    endtask

    task automatic push(input string tag, input logic [7:0] c, input logic [7:0] s,
                        input logic [15:0] d, input logic cd);
        exp_s e;
        e.tag = tag; e.cmd = c; e.status = s; e.data = d; e.chk_data = cd;
        sb_q.push_back(e);
    endtask

    // full transfer: mid_wr injects host writes during the transfer (R11)
    task automatic xfer(input string tag, input logic [7:0] c, input logic [15:0] tx,
                        input logic [15:0] rx, input bit mid_wr);
        int len;
        logic mi;
        logic rise;
        len  = (c[3:0] == 0) ? 16 : int'(c[3:0]);
        rise = c[6];
        spi_sclk = rise;
        host_wr(1, tx);
        host_wr(0, {8'h00, c});
        cyc(4);
        spi_ss_n = 1'b0;
        cyc(6);
        chk(busy === 1'b1, {tag, " R11 busy"}, busy, 1);
        for (int i = 0; i < len; i++) begin
            bit_xfer(rise, rx[len-1-i], mi);
            // R4 R6 R7: MISO carries aligned word MSB first
            chk(mi === tx[len-1-i], {tag, " R4 miso"}, mi, tx[len-1-i]);
            if (mid_wr && i == 1) begin
                host_wr(1, 16'hFFFF);
                host_wr(0, 16'h005F);
            end
        end
        cyc(6);
        spi_ss_n = 1'b1;
        chk(busy === 1'b0, {tag, " R10 idle"}, busy, 0);
        // R5: buffer holds received word, zeros above
        push({tag, " R5 R10"}, 8'h00, 8'h00,
             (len == 16) ? rx : (rx & 16'((1 << len) - 1)), 1'b1);
        cyc(4);
    endtask

    // scoreboard monitor
    initial begin
        forever begin
            wait (sb_q.size() > 0);
            @(negedge clk);
            begin
                exp_s e;
                e = sb_q.pop_front();
                chk(cmd_rd === e.cmd, {e.tag, " cmd"}, cmd_rd, e.cmd);
                chk(status_rd === e.status, {e.tag, " status"}, status_rd, e.status);
                if (e.chk_data)
                    chk(buf_rd === e.data, {e.tag, " buf"}, buf_rd, e.data);
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic mi;
        cyc(3);
        rst_n = 1'b1;
        cyc(2);
        // R12 reset state
        chk(cmd_rd === 8'h00, "R12 reset cmd", cmd_rd, 0);
        chk(status_rd === 8'h00, "R12 reset status", status_rd, 0);
        chk(buf_rd === 16'h0000, "R12 reset buf", buf_rd, 0);
        chk(busy === 1'b0, "R12 reset busy", busy, 0);

        host_wr(2, 16'd20);

        xfer("R6 8b fall", 8'h18, 16'h00A5, 16'h003C, 1'b0);
        xfer("R7 R3 16b rise", 8'h50, 16'hC3A1, 16'h5E17, 1'b0);
        xfer("R3 1b xmit", 8'h91, 16'hFFF1, 16'h0001, 1'b0);
        xfer("R1 R4 12b rise", 8'hDC, 16'hF9B6, 16'h0A53, 1'b0);
        xfer("R11 busy writes", 8'h16, 16'h0029, 16'h0017, 1'b1);

        // R2: illegal commands (master bit, then bit 4 clear)
        host_wr(1, 16'h1234);
        host_wr(0, 16'h0038);
        cyc(3);
        spi_ss_n = 1'b0;
        cyc(10);
        chk(busy === 1'b0, "R2 no busy", busy, 0);
        spi_ss_n = 1'b1;
        push("R2 master bit", 8'h00, 8'h10, 16'h1234, 1'b1);
        cyc(6);
        host_wr(0, 16'h0008);
        chk(status_rd === 8'h00, "R10 status cleared", status_rd, 0);
        cyc(3);
        spi_ss_n = 1'b0;
        cyc(10);
        chk(busy === 1'b0, "R2 no busy b4", busy, 0);
        spi_ss_n = 1'b1;
        push("R2 bit4 clear", 8'h00, 8'h10, 16'h1234, 1'b1);
        cyc(6);

        // R12: clocking with slave-select high starts nothing
        host_wr(0, 16'h0018);
        spi_sclk = 1'b0;
        for (int i = 0; i < 4; i++) begin
            spi_sclk = 1'b1; cyc(H);
            spi_sclk = 1'b0; cyc(H);
        end
        chk(busy === 1'b0, "R12 no start", busy, 0);
        chk(cmd_rd === 8'h18, "R12 cmd kept", cmd_rd, 8'h18);

        // R8: stall after three bits, timeout 10 ticks of 4 cycles
        host_wr(2, 16'd10);
        cyc(3);
        spi_ss_n = 1'b0;
        cyc(6);
        for (int i = 0; i < 3; i++) bit_xfer(1'b0, 1'b1, mi);
        cyc(23);
        chk(busy === 1'b1, "R8 still waiting", busy, 1);
        cyc(15);
        chk(busy === 1'b0, "R8 aborted", busy, 0);
        spi_ss_n = 1'b1;
        push("R8 abort", 8'h00, 8'h80, 16'h0000, 1'b0);
        cyc(6);

        // R9: timeout 0 means 256 ticks
        host_wr(0, 16'h0018);
        host_wr(2, 16'd0);
        chk(status_rd === 8'h00, "R10 status cleared 2", status_rd, 0);
        cyc(3);
        spi_ss_n = 1'b0;
        cyc(1000);
        chk(busy === 1'b1, "R9 still waiting", busy, 1);
        cyc(45);
        chk(busy === 1'b0, "R9 aborted", busy, 0);
        spi_ss_n = 1'b1;
        push("R9 abort", 8'h00, 8'h80, 16'h0000, 1'b0);
        cyc(10);

        wait (sb_q.size() == 0);
        cyc(2);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule